// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into host memory. The host keeps a ring of 16-byte receive descriptors. Each one holds a buffer address at offset 0. The word at offset 4 holds a 16-bit buffer length in its low half, stored as the negative of the byte count, and a 16-bit status in its high half. Offset 8 holds the message length word and offset 12 is reserved. The host hands a descriptor to the engine by setting status bit 15. While no frame is in progress, the engine keeps reading the current descriptor. When a frame begins, it therefore already knows whether it may store the frame and where.

Frame bytes arrive one per cycle on a stream with start-of-frame, end-of-frame and error flags, and there is no back-pressure. Bytes go to the buffer one byte lane at a time through a simple word-wide memory port with a one-cycle read latency. When the frame ends, the engine writes the message length. After that it writes the status half-word, which carries the completion bits and returns ownership to the host. The ring index then advances modulo the ring size. A frame that finds no host-owned descriptor is discarded and counted.

Top module: `rxr_engine`

## Requirements
- R1: After reset the engine issues no memory write and the missed-frame count reads 0.
- R2: Frame bytes are written only into a descriptor whose status bit 15 (bit 31 of the word at offset 4) was set. A frame that starts while no such descriptor has been confirmed causes no memory write, and the missed-frame count goes up by exactly one.
- R3: Byte k of a frame is stored at buffer address + k. It goes to the 32-bit word at that address with bits [1:0] cleared, in byte lane = address bits [1:0] (little-endian).
- R4: The buffer limit is the two's-complement negation of the low 16 bits of the word at offset 4. Bytes past the limit are not written, and the overflow bit 0x10 is set in the status high byte.
- R5: The low 12 bits of the word at offset 8 receive the number of bytes stored, which includes the 4-byte check sequence carried in the stream. The upper 20 bits are written as 0.
- R6: The status high byte written back (bits 31:24 of the word at offset 4) has bit 7 (ownership) cleared and always carries 0x02 (start) and 0x01 (end). It adds 0x20 for a framing error, 0x08 for a CRC error and 0x04 for a buffer error, each taken from the input flag on the last byte. A clean frame reads 0x03 and the low status byte is written as 0.
- R7: The length word is written in the cycle just before the status half-word, and the status write is the final write for that descriptor.
- R8: Descriptor i lives at ring base + 16*i. After each write-back the index advances by one, modulo 2^k, where k is bits 7:4 of the ring-length word (capped at the parameter MAX_LOG2).
- R9: The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 |
| cfg_ring_len | input | 16 | Ring-length word; bits 7:4 hold log2 of the entry count |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_frm_err | input | 1 | Framing error, valid with the last byte |
| in_crc_err | input | 1 | CRC error, valid with the last byte |
| in_fifo_err | input | 1 | Buffer/FIFO error, valid with the last byte |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |
| miss_count | output | MISS_W | Number of frames discarded for lack of a descriptor |

## Verification
The assertions assume that the stream stays silent while the engine writes back a descriptor. This means a gap of at least two idle cycles after every last byte, and at least one polling pass before the next frame is expected to be stored. They also assume that the ring configuration does not change while frames are in flight. The stimulus follows these rules. Every frame is followed by ten idle cycles, the host arms a descriptor and then waits ten cycles before sending, and the ring base and length stay fixed for the whole run. The error flags are driven only with the last byte of a frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_POLL_HDR,
    ST_POLL_BASE,
    ST_POLL_CHK,
    ST_READY,
    ST_RECV,
    ST_DROP,
    ST_WB_LEN,
    ST_WB_STAT
  } rxr_state_e;

  // descriptor layout (bytes from descriptor start)
  localparam logic [31:0] DESC_OFS_BUF  = 32'd0;
  localparam logic [31:0] DESC_OFS_CTL  = 32'd4;
  localparam logic [31:0] DESC_OFS_MLEN = 32'd8;
  localparam int          DESC_SHIFT    = 4;
  localparam int          MLEN_W        = 12;

  // completion bits of the status high byte
  localparam logic [7:0] STB_FRAME  = 8'h20;
  localparam logic [7:0] STB_OVF    = 8'h10;
  localparam logic [7:0] STB_CRC    = 8'h08;
  localparam logic [7:0] STB_BUFERR = 8'h04;
  localparam logic [7:0] STB_START  = 8'h02;
  localparam logic [7:0] STB_END    = 8'h01;

  function automatic logic [7:0] rxr_status_hi(input logic frm, input logic ovf,
                                               input logic crc, input logic buferr);
    logic [7:0] s;
    s = STB_START | STB_END;
    if (frm)    s = s | STB_FRAME;
    if (ovf)    s = s | STB_OVF;
    if (crc)    s = s | STB_CRC;
    if (buferr) s = s | STB_BUFERR;
    return s;
  endfunction

endpackage

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
  parameter int MAX_LOG2 = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          log2_in,
  input  logic                advance,
  output logic [MAX_LOG2-1:0] idx
);

  localparam logic [MAX_LOG2-1:0] IdxOne = 1;

  logic [3:0]          lg;
  logic [MAX_LOG2:0]   span;
  logic [MAX_LOG2-1:0] mask;
  logic [MAX_LOG2-1:0] idx_d;
  logic [MAX_LOG2-1:0] idx_q;

  always_comb begin
    lg    = (log2_in > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : log2_in;
    span  = {{MAX_LOG2{1'b0}}, 1'b1} << lg;
    mask  = span[MAX_LOG2-1:0] - IdxOne;
    idx_d = (idx_q + IdxOne) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign idx = idx_q;

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q & ~mask) == '0) else $error("ring index outside ring"); // R8

endmodule

// File: rtl/rxr_fill.sv
module rxr_fill #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             byte_in,
  input  logic [LEN_W-1:0] limit,
  output logic             wr_en,
  output logic [LEN_W-1:0] count,
  output logic             overflow
);

  localparam logic [LEN_W-1:0] CntOne = 1;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             room;
  logic             cnt_en, ovf_en;

  always_comb begin
    room   = (cnt_q < limit);
    wr_en  = byte_in && room;
    cnt_en = start || wr_en;
    cnt_d  = start ? '0 : (cnt_q + CntOne);
    ovf_en = start || (byte_in && !room);
    ovf_d  = !start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  assign count    = cnt_q;
  assign overflow = ovf_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    byte_in |-> (cnt_q <= limit)) else $error("fill count past buffer limit"); // R4

endmodule

// File: rtl/rxr_desc_cache.sv
module rxr_desc_cache (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_hdr,
  input  logic        cap_base,
  input  logic        drop,
  input  logic [31:0] rdata,
  output logic        owned,
  output logic [15:0] limit,
  output logic [31:0] buf_base
);

  logic        own_q;
  logic [15:0] len_q;
  logic [31:0] base_q;
  logic        own_en;

  assign own_en = cap_hdr || drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= 1'b0;
    else if (own_en) own_q <= cap_hdr && rdata[31];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (cap_hdr) len_q <= rdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (cap_base) base_q <= rdata;
  end

  assign owned    = own_q;
  assign limit    = 16'(~len_q + 16'd1);
  assign buf_base = base_q;

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int MAX_LOG2 = 7,
  parameter int MISS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_ring_base,
  input  logic [15:0]       cfg_ring_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_frm_err,
  input  logic              in_crc_err,
  input  logic              in_fifo_err,
  output logic              mem_re,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [MISS_W-1:0] miss_count
);

  localparam int LEN_W  = 16;
  localparam int ADDR_PAD = 32 - MAX_LOG2 - DESC_SHIFT;
  localparam logic [MISS_W-1:0] MissOne = 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  rxr_state_e state_q, state_d;

  logic [MAX_LOG2-1:0] ring_idx;
  logic [31:0]         desc_addr;
  logic [31:0]         byte_addr;
  logic                owned;
  logic [15:0]         limit;
  logic [31:0]         buf_base;
  logic                fill_wr;
  logic [LEN_W-1:0]    fill_cnt;
  logic                fill_ovf;

  logic cap_hdr, cap_base, desc_drop, fill_start, byte_in;
  logic err_cap, miss_inc, ring_adv;
  logic frame_start;

  logic        fsm_re, fsm_we;
  logic [31:0] fsm_addr, fsm_wdata;
  logic [3:0]  fsm_be;

  logic       frm_q, crc_q, fifo_q;
  logic [7:0] stat_hi;
  logic [MISS_W-1:0] miss_q;

  logic unused_bits;
  assign unused_bits = ^{cfg_ring_len[15:8], cfg_ring_len[3:0], fill_cnt[LEN_W-1:MLEN_W]};

  rxr_ring_idx #(.MAX_LOG2(MAX_LOG2)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .log2_in (cfg_ring_len[7:4]),
    .advance (ring_adv),
    .idx     (ring_idx)
  );

  rxr_desc_cache u_cache (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cap_hdr  (cap_hdr),
    .cap_base (cap_base),
    .drop     (desc_drop),
    .rdata    (mem_rdata),
    .owned    (owned),
    .limit    (limit),
    .buf_base (buf_base)
  );

  rxr_fill #(.LEN_W(LEN_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (fill_start),
    .byte_in  (byte_in),
    .limit    (limit),
    .wr_en    (fill_wr),
    .count    (fill_cnt),
    .overflow (fill_ovf)
  );

  assign desc_addr = cfg_ring_base + {{ADDR_PAD{1'b0}}, ring_idx, {DESC_SHIFT{1'b0}}};
  assign byte_addr = buf_base + {16'h0000, fill_cnt};
  assign stat_hi   = rxr_status_hi(frm_q, fill_ovf, crc_q, fifo_q);
  assign frame_start = in_valid && in_sof;

  // next state and descriptor-side accesses
  always_comb begin
    state_d    = state_q;
    fsm_re     = 1'b0;
    fsm_we     = 1'b0;
    fsm_addr   = 32'h0;
    fsm_be     = 4'h0;
    fsm_wdata  = 32'h0;
    cap_hdr    = 1'b0;
    cap_base   = 1'b0;
    desc_drop  = 1'b0;
    fill_start = 1'b0;
    byte_in    = 1'b0;
    err_cap    = 1'b0;
    miss_inc   = 1'b0;
    ring_adv   = 1'b0;
    case (state_q)
      ST_POLL_HDR: begin
        fsm_re   = 1'b1;
        fsm_addr = desc_addr + DESC_OFS_CTL;
        if (frame_start) begin
          miss_inc = 1'b1;
          state_d  = in_eof ? ST_POLL_HDR : ST_DROP;
        end else begin
          state_d  = ST_POLL_BASE;
        end
      end
      ST_POLL_BASE: begin
        cap_hdr  = 1'b1;
        fsm_re   = 1'b1;
        fsm_addr = desc_addr + DESC_OFS_BUF;
        if (frame_start) begin
          miss_inc = 1'b1;
          state_d  = in_eof ? ST_POLL_HDR : ST_DROP;
        end else begin
          state_d  = ST_POLL_CHK;
        end
      end
      ST_POLL_CHK: begin
        cap_base   = 1'b1;
        fill_start = 1'b1;
        if (frame_start) begin
          miss_inc = 1'b1;
          state_d  = in_eof ? ST_POLL_HDR : ST_DROP;
        end else begin
          state_d  = owned ? ST_READY : ST_POLL_HDR;
        end
      end
      ST_READY: begin
        if (frame_start) begin
          byte_in = 1'b1;
          if (in_eof) begin
            err_cap = 1'b1;
            state_d = ST_WB_LEN;
          end else begin
            state_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (in_valid) begin
          byte_in = 1'b1;
          if (in_eof) begin
            err_cap = 1'b1;
            state_d = ST_WB_LEN;
          end
        end
      end
      ST_DROP: begin
        if (in_valid && in_eof) state_d = ST_POLL_HDR;
      end
      ST_WB_LEN: begin
        fsm_we    = 1'b1;
        fsm_be    = 4'hF;
        fsm_addr  = desc_addr + DESC_OFS_MLEN;
        fsm_wdata = {{(32-MLEN_W){1'b0}}, fill_cnt[MLEN_W-1:0]};
        state_d   = ST_WB_STAT;
      end
      ST_WB_STAT: begin
        fsm_we    = 1'b1;
        fsm_be    = 4'hC;
        fsm_addr  = desc_addr + DESC_OFS_CTL;
        fsm_wdata = {1'b0, stat_hi[6:0], 8'h00, 16'h0000};
        ring_adv  = 1'b1;
        desc_drop = 1'b1;
        state_d   = ST_POLL_HDR;
      end
      default: state_d = ST_POLL_HDR;
    endcase
  end

  // memory port: buffer byte writes merge with descriptor accesses
  always_comb begin
    mem_re    = fsm_re;
    mem_we    = fsm_we;
    mem_addr  = fsm_addr;
    mem_be    = fsm_be;
    mem_wdata = fsm_wdata;
    if (fill_wr) begin
      mem_we    = 1'b1;
      mem_addr  = {byte_addr[31:2], 2'b00};
      mem_be    = 4'b0001 << byte_addr[1:0];
      mem_wdata = {4{in_data}};
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= ST_POLL_HDR;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      frm_q  <= 1'b0;
      crc_q  <= 1'b0;
      fifo_q <= 1'b0;
    end else if (err_cap) begin
      frm_q  <= in_frm_err;
      crc_q  <= in_crc_err;
      fifo_q <= in_fifo_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)      miss_q <= '0;
    else if (miss_inc) miss_q <= miss_q + MissOne;
  end

  assign miss_count = miss_q;

  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(mem_re && mem_we)) else $error("read and write in one cycle"); // R9

  AST_STATUS_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_we && mem_be == 4'hC) |-> $past(mem_we && mem_be == 4'hF)) else $error("status before length"); // R7

  AST_QUIET_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_WB_LEN || state_q == ST_WB_STAT) |-> !in_valid) else $error("byte during write-back"); // R7

  AST_OWNED_WRITE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_we && $countones(mem_be) == 1) |-> owned) else $error("byte write without ownership"); // R2

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n_i)
    (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + MissOne)) else $error("miss count jump"); // R2

endmodule

// File: tb/sim_rxr_engine.sv
`timescale 1ns/1ps
module sim_rxr_engine;

  localparam logic [31:0] RING = 32'h0000_0040;
  localparam int MEM_WORDS = 4096;

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  st;
    logic [11:0] len;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, in_frm_err, in_crc_err, in_fifo_err;
  logic [7:0]  in_data;
  logic        mem_re, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [7:0]  miss_count;

  logic        hw_en;
  logic [31:0] hw_addr, hw_data;
  logic        quiet;
  logic [31:0] mem [MEM_WORDS];

  exp_t sb[$];
  int   n_checks = 0;
  int   n_errs   = 0;

  always #2.5 clk = ~clk;

  rxr_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(RING), .cfg_ring_len(16'h0020),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_frm_err(in_frm_err), .in_crc_err(in_crc_err), .in_fifo_err(in_fifo_err),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .miss_count(miss_count)
  );

  // host memory model, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= 32'h0;
      mem_rdata <= 32'h0;
    end else begin
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (hw_en) mem[hw_addr[13:2]] <= hw_data;
      if (mem_re) mem_rdata <= mem[mem_addr[13:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem[a[13:2]][8*a[1:0] +: 8];
  endfunction

  // monitor: pops expected write-backs and compares
  initial begin
    logic        len_prev;
    logic [31:0] len_addr;
    logic [11:0] len_val;
    exp_t        e;
    len_prev = 1'b0;
    len_addr = 32'h0;
    len_val  = 12'h0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (quiet && mem_we) chk(1'b0, "R2", "write during missed frame", mem_addr, 0);
      if (mem_we && mem_be == 4'hC) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected write-back", mem_addr, 0);
        end else begin
          e = sb.pop_front();
          chk(mem_addr == e.addr, "R8", "descriptor address", mem_addr, e.addr);
          chk(mem_wdata[31:16] == {e.st, 8'h00}, "R6", "status half-word",
              mem_wdata[31:16], {e.st, 8'h00});
          chk(len_prev && len_addr == e.addr + 32'd4, "R7", "length just before status",
              len_addr, e.addr + 32'd4);
          chk(len_val == e.len, "R5", "message length", len_val, e.len);
        end
      end
      if (mem_we && mem_be == 4'hF) begin
        len_prev = 1'b1;
        len_addr = mem_addr;
        len_val  = mem_wdata[11:0];
        chk(mem_wdata[31:12] == 20'h0, "R5", "length upper bits", mem_wdata[31:12], 0);
      end else begin
        len_prev = 1'b0;
      end
    end
  end

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic arm(input int idx, input logic [31:0] base, input int size);
    host_wr(RING + 32'(idx * 16), base);
    host_wr(RING + 32'(idx * 16 + 4), {16'h8000, 16'(-size)});
    repeat (10) @(negedge clk);
  endtask

  // driver: pushes the expected write-back, then plays the frame
  task automatic send_frame(input int n, input int seed, input bit fe, input bit crc,
                            input bit fifo, input bit owned, input int idx, input int bsize);
    exp_t e;
    int   stored;
    stored = (n < bsize) ? n : bsize;
    if (owned) begin
      e.addr = RING + 32'(idx * 16 + 4);
      e.st   = 8'h03 | (fe ? 8'h20 : 8'h00) | ((n > bsize) ? 8'h10 : 8'h00)
                     | (crc ? 8'h08 : 8'h00) | (fifo ? 8'h04 : 8'h00);
      e.len  = 12'(stored);
      sb.push_back(e);
    end
    quiet = !owned;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_data     = 8'(seed + i);
      in_sof      = (i == 0);
      in_eof      = (i == n - 1);
      in_frm_err  = (i == n - 1) && fe;
      in_crc_err  = (i == n - 1) && crc;
      in_fifo_err = (i == n - 1) && fifo;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    in_frm_err = 1'b0; in_crc_err = 1'b0; in_fifo_err = 1'b0;
    repeat (10) @(negedge clk);
    quiet = 1'b0;
    if (owned) chk(sb.size() == 0, "R7", "write-back completed", sb.size(), 0);
  endtask

  task automatic check_buf(input int idx, input logic [31:0] base, input int n,
                           input int bsize, input int seed);
    int stored;
    int bad;
    stored = (n < bsize) ? n : bsize;
    bad = -1;
    for (int i = 0; i < stored; i++)
      if (bad < 0 && rd_byte(base + 32'(i)) != 8'(seed + i)) bad = i;
    chk(bad < 0, "R3", "buffer contents (first bad offset)", bad, -1);
    if (n > bsize)
      chk(rd_byte(base + 32'(bsize)) == 8'h00, "R4", "byte past limit untouched",
          rd_byte(base + 32'(bsize)), 0);
    chk(mem[(RING[13:2]) + 12'(idx * 4 + 1)][31] == 1'b0, "R6", "ownership cleared",
        mem[(RING[13:2]) + 12'(idx * 4 + 1)][31], 0);
  endtask

  initial begin
    rst_n = 1'b0; hw_en = 1'b0; hw_addr = '0; hw_data = '0; quiet = 1'b0;
    in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    in_frm_err = 1'b0; in_crc_err = 1'b0; in_fifo_err = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(mem_we == 1'b0, "R1", "no write after reset", mem_we, 0);
    chk(miss_count == 8'd0, "R1", "miss count after reset", miss_count, 0);

    // R2: nothing armed, frame discarded
    send_frame(30, 8'h21, 0, 0, 0, 0, 0, 0);
    chk(miss_count == 8'd1, "R2", "miss count after first drop", miss_count, 1);

    // clean minimum frame
    arm(0, 32'h0000_1000, 1544);
    send_frame(64, 8'h40, 0, 0, 0, 1, 0, 1544);
    check_buf(0, 32'h0000_1000, 64, 1544, 8'h40);

    // CRC error into an unaligned buffer (R3 lanes)
    arm(1, 32'h0000_1801, 1544);
    send_frame(70, 8'h05, 0, 1, 0, 1, 1, 1544);
    check_buf(1, 32'h0000_1801, 70, 1544, 8'h05);

    // overflow cut-off, R4
    arm(2, 32'h0000_2000, 32);
    send_frame(40, 8'h11, 0, 0, 0, 1, 2, 32);
    check_buf(2, 32'h0000_2000, 40, 32, 8'h11);

    // framing and buffer error together
    arm(3, 32'h0000_2802, 100);
    send_frame(64, 8'h77, 1, 0, 1, 1, 3, 100);
    check_buf(3, 32'h0000_2802, 64, 100, 8'h77);

    // wrap to entry 0, frame exactly fills the default-size buffer (R8)
    arm(0, 32'h0000_1000, 1544);
    send_frame(1544, 8'h09, 0, 0, 0, 1, 0, 1544);
    check_buf(0, 32'h0000_1000, 1544, 1544, 8'h09);

    // entry 1 was returned to the host: next frame missed
    send_frame(64, 8'h33, 0, 0, 0, 0, 1, 0);
    chk(miss_count == 8'd2, "R2", "miss count after returned entry", miss_count, 2);

    // re-arm entry 1, exact-fit small buffer
    arm(1, 32'h0000_3000, 48);
    send_frame(48, 8'h61, 0, 0, 0, 1, 1, 48);
    check_buf(1, 32'h0000_3000, 48, 48, 8'h61);
    chk(miss_count == 8'd2, "R2", "miss count unchanged by stored frame", miss_count, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog (R1..all): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule